// File: doc/BRIEF.md
# Serial Shift Clock Divider

This block derives the shift clock for a serial port in master mode from the system clock. A 7-bit divide value N sets an even ratio of 2×(N+1), so one shift-clock period lasts anywhere from 2 to 256 system cycles. A separate bypass bit runs the shift clock at the full system-clock rate and ignores N. When the port is a slave, the block makes no clock at all, and the divide value and the bypass bit have no effect.

Beside the shift clock, the block gives two strobes, each one system cycle wide, that mark the rising and falling edges of the shift clock. A downstream shift register clocked by the system clock uses them as enables, so it never needs the shift clock as a clock. The block runs only while a transfer is active. Between transfers its counter is held cleared and the shift clock rests low, so every transfer begins with a fresh low half-period.

Top module: `shift_clk_gen`

## Requirements
- R1: While reset is asserted, and after it until a transfer starts, `sclk_o`, `lead_o` and `trail_o` are 0. Reset also clears the stored divide value to 0.
- R2: In master mode with bypass clear and `run_i` high, the first rising edge of `sclk_o` follows the (N+1)th active clock edge. After that, `sclk_o` stays high for N+1 cycles and low for N+1 cycles.
- R3: In divider mode, `lead_o` is high for exactly the one cycle in which `sclk_o` has just risen. `trail_o` is high for exactly the one cycle in which `sclk_o` has just fallen. The two strobes are never high together.
- R4: In master mode with `bypass_i` = 1 and `run_i` high, starting one cycle after the inputs are sampled, `sclk_o` equals the system clock (high in the high phase, low in the low phase), both strobes are high in every cycle, and the value of `div_i` has no effect.
- R5: With `master_i` = 0 (slave), `sclk_o` stays low and both strobes stay 0, whatever the values of `run_i`, `div_i` and `bypass_i`.
- R6: With `run_i` low, the counter is held cleared and `sclk_o` is low with no strobes. A transfer that starts again begins with a full low half-period of N+1 cycles.
- R7: The divide value is sampled only when a half-period ends, or while no divided transfer is running. A change in the middle of a half-period leaves that half-period at its old length, and the new length applies to the half-period that follows.
- R8: N = 127 gives the largest ratio, 256 cycles: 128 cycles high and 128 cycles low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_i | input | 1 | 1 = master mode (clock is generated), 0 = slave |
| run_i | input | 1 | A transfer is active |
| div_i | input | 7 | Divide value N, ratio 2×(N+1) |
| bypass_i | input | 1 | 1 = divide by one (shift clock equals system clock) |
| sclk_o | output | 1 | Shift clock |
| lead_o | output | 1 | One-cycle strobe on each rising shift-clock edge |
| trail_o | output | 1 | One-cycle strobe on each falling shift-clock edge |

## Verification
The divider is run with N = 0, a small N, an odd-length N and N = 127. Together these separate an off-by-one in the reload compare from a wrong toggle point, and confirm that the ratio is even and covers the full range. A change of divide value in the middle of a half-period tells reload-time sampling apart from immediate sampling. An idle gap followed by a restart shows whether a stale count or phase leaks into the next transfer. Bypass runs with a large N, and slave mode runs with every other input set, and each of them shows that the ignored inputs really are ignored at the output pins.

// File: rtl/sck_pkg.sv
`timescale 1ns/1ps
package sck_pkg;
   localparam int unsigned DIV_W_DEF = 7;
   localparam int unsigned DIV_W_MAX = 16;

   typedef struct packed {
      logic lead;
      logic trail;
   } sck_edge_t;
endpackage

// File: rtl/sck_div_count.sv
`timescale 1ns/1ps
module sck_div_count #(
   parameter int unsigned DIV_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             wrap_o
);
   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] lim_q;
   logic             at_lim;

   assign at_lim = (cnt_q == lim_q);
   assign wrap_o = run_i & at_lim;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lim_q <= '0;
      end else if (!run_i) begin
         cnt_q <= '0;
         lim_q <= div_i;
      end else if (at_lim) begin
         cnt_q <= '0;
         lim_q <= div_i;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R6: an idle cycle leaves the counter cleared
   a_r6_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> (cnt_q == '0));
   // R2: the count never passes the latched limit
   a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= lim_q);
   // R7: the limit does not move inside a running half-period
   a_r7_lim_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !at_lim) |=> $stable(lim_q));
endmodule

// File: rtl/sck_phase.sv
`timescale 1ns/1ps
module sck_phase
   import sck_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      run_i,
   input  logic      wrap_i,
   output logic      sclk_o,
   output sck_edge_t edge_o
);
   logic      phase_q;
   sck_edge_t edge_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= 1'b0;
         edge_q  <= '0;
      end else if (!run_i) begin
         phase_q <= 1'b0;
         edge_q  <= '0;
      end else if (wrap_i) begin
         phase_q      <= ~phase_q;
         edge_q.lead  <= ~phase_q;
         edge_q.trail <= phase_q;
      end else begin
         edge_q <= '0;
      end
   end

   assign sclk_o = phase_q;
   assign edge_o = edge_q;

   // R3: rising strobe marks exactly a fresh high phase
   a_r3_lead_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      edge_q.lead |-> (phase_q && !$past(phase_q)));
   // R3: falling strobe marks exactly a fresh low phase
   a_r3_trail_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      edge_q.trail |-> (!phase_q && $past(phase_q)));
   // R3: strobes never coincide in divider mode
   a_r3_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({edge_q.lead, edge_q.trail}));
endmodule

// File: rtl/shift_clk_gen.sv
`timescale 1ns/1ps
module shift_clk_gen
   import sck_pkg::*;
#(
   parameter int unsigned DIV_W     = DIV_W_DEF,
   parameter bit          BYPASS_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             master_i,
   input  logic             run_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic             bypass_i,
   output logic             sclk_o,
   output logic             lead_o,
   output logic             trail_o
);
   localparam int unsigned MAX_RATIO = 2 * (1 << DIV_W);

   generate
      if (DIV_W < 1 || DIV_W > DIV_W_MAX) begin : g_bad_width
         $error("shift_clk_gen: DIV_W out of range");
      end
      if (MAX_RATIO < 4) begin : g_bad_ratio
         $error("shift_clk_gen: ratio range too small");
      end
   endgenerate

   logic      active;
   logic      byp_sel;
   logic      div_run;
   logic      wrap;
   logic      phase;
   sck_edge_t edges;
   logic      byp_q;

   assign active = master_i & run_i;

   generate
      if (BYPASS_EN) begin : g_bypass
         assign byp_sel = bypass_i;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) byp_q <= 1'b0;
            else        byp_q <= active & bypass_i;
         end
      end else begin : g_no_bypass
         assign byp_sel = 1'b0;
         assign byp_q   = 1'b0;
      end
   endgenerate

   assign div_run = active & ~byp_sel;

   sck_div_count #(.DIV_W(DIV_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (div_run),
      .div_i  (div_i),
      .wrap_o (wrap)
   );

   sck_phase u_phase (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (div_run),
      .wrap_i (wrap),
      .sclk_o (phase),
      .edge_o (edges)
   );

   assign sclk_o  = byp_q ? clk : phase;
   assign lead_o  = byp_q | edges.lead;
   assign trail_o = byp_q | edges.trail;

   // R5: slave mode leaves both clock sources quiet
   a_r5_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !master_i |=> (!phase && !byp_q));
   // R4: bypass gives both strobes each cycle
   a_r4_byp_strobes: assert property (@(posedge clk) disable iff (!rst_n)
      byp_q |-> (lead_o && trail_o));
   // R4: divided phase is parked while bypassing
   a_r4_byp_parks_div: assert property (@(posedge clk) disable iff (!rst_n)
      byp_q |-> (!phase && !edges.lead && !edges.trail));
endmodule

// File: tb/sim_shift_clk_gen.sv
`timescale 1ns/1ps
module sim_shift_clk_gen;
   typedef struct {
      bit    hi;
      bit    lo;
      bit    ld;
      bit    tr;
      string tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       master_i = 1'b0;
   logic       run_i = 1'b0;
   logic [6:0] div_i = 7'd0;
   logic       bypass_i = 1'b0;
   logic       sclk_o, lead_o, trail_o;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done = 1'b0;
   exp_t q[$];

   int  m_pos = 0;
   int  m_h = 1;
   bit  m_sclk = 1'b0;

   always #2 clk = ~clk;

   shift_clk_gen u0 (
      .clk(clk), .rst_n(rst_n), .master_i(master_i), .run_i(run_i),
      .div_i(div_i), .bypass_i(bypass_i),
      .sclk_o(sclk_o), .lead_o(lead_o), .trail_o(trail_o)
   );

   // driver: apply inputs for the next edge and push the expected outputs
   task automatic cyc(input bit ma, input bit ru, input bit by,
                      input int dv, input string tag);
      exp_t e;
      bit act, bp;
      @(posedge clk);
      #1.5;
      master_i = ma; run_i = ru; bypass_i = by; div_i = dv[6:0];
      act = ma && ru && !by;
      bp  = ma && ru && by;
      e.ld = 1'b0; e.tr = 1'b0; e.tag = tag;
      if (!act) begin
         m_pos = 0; m_sclk = 1'b0; m_h = dv + 1;
      end else begin
         m_pos++;
         if (m_pos == m_h) begin
            m_sclk = ~m_sclk;
            e.ld = m_sclk; e.tr = ~m_sclk;
            m_pos = 0; m_h = dv + 1;
         end
      end
      if (bp) begin
         e.hi = 1'b1; e.lo = 1'b0; e.ld = 1'b1; e.tr = 1'b1;
      end else begin
         e.hi = m_sclk; e.lo = m_sclk;
      end
      q.push_back(e);
   endtask

   task automatic run_n(input int n, input bit ma, input bit ru, input bit by,
                        input int dv, input string tag);
      for (int i = 0; i < n; i++) cyc(ma, ru, by, dv, tag);
   endtask

   // monitor: sample in the high phase and again in the low phase
   initial begin
      exp_t e;
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            e = q.pop_front();
            n_chk++;
            if (sclk_o !== e.hi || lead_o !== e.ld || trail_o !== e.tr) begin
               n_bad++;
               $display("FAIL %s high phase: sclk/lead/trail act=%b%b%b exp=%b%b%b",
                        e.tag, sclk_o, lead_o, trail_o, e.hi, e.ld, e.tr);
            end
            #2;
            n_chk++;
            if (sclk_o !== e.lo) begin
               n_bad++;
               $display("FAIL %s low phase: sclk act=%b exp=%b", e.tag, sclk_o, e.lo);
            end
         end
      end
   end

   initial begin
      #400000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: act=hung exp=finished");
         $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      n_chk++;  // R1 in reset
      if (sclk_o !== 1'b0 || lead_o !== 1'b0 || trail_o !== 1'b0) begin
         n_bad++;
         $display("FAIL R1 in reset: act=%b%b%b exp=000", sclk_o, lead_o, trail_o);
      end
      @(posedge clk); #1.5;
      rst_n = 1'b1;
      run_n(3, 1'b1, 1'b0, 1'b0, 0, "R1");
      run_n(12, 1'b1, 1'b1, 1'b0, 0, "R2");          // N=0, ratio 2
      run_n(3, 1'b1, 1'b0, 1'b0, 3, "R6");
      run_n(30, 1'b1, 1'b1, 1'b0, 3, "R3");          // N=3, ratio 8
      run_n(20, 1'b1, 1'b1, 1'b0, 2, "R2");          // N=2 ...
      run_n(2, 1'b1, 1'b0, 1'b0, 2, "R6");           // idle mid-period
      run_n(15, 1'b1, 1'b1, 1'b0, 2, "R6");          // fresh restart
      run_n(2, 1'b1, 1'b0, 1'b0, 5, "R7");
      run_n(8, 1'b1, 1'b1, 1'b0, 5, "R7");           // mid half-period
      run_n(20, 1'b1, 1'b1, 1'b0, 1, "R7");          // new value later
      run_n(10, 1'b1, 1'b1, 1'b1, 9, "R4");          // bypass, N ignored
      run_n(10, 1'b1, 1'b1, 1'b0, 1, "R3");
      run_n(6, 1'b0, 1'b1, 1'b0, 0, "R5");
      run_n(6, 1'b0, 1'b1, 1'b1, 4, "R5");
      run_n(2, 1'b1, 1'b0, 1'b0, 127, "R8");
      run_n(600, 1'b1, 1'b1, 1'b0, 127, "R8");       // ratio 256
      run_n(3, 1'b1, 1'b0, 1'b0, 0, "R6");
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule